// File: doc/BRIEF.md
# Status Register Write-Protect Controller

This block keeps the status byte of a serial nonvolatile memory and rules on every write that reaches it. A command decoder hands it three kinds of one-cycle request: a write-enable request that arms the write-enable latch, a status write with its data byte, and an array write with its target address. The block also watches the level of the write-protect pin. For each status or array write it answers with a grant or a deny pulse. On a grant it starts a nonvolatile write cycle of fixed length, during which the write-in-progress flag is high.

Two block-lock bits mark the upper part of the array as read-only. A protect-enable bit, together with a low write-protect pin, freezes the status byte itself. Writing the protect-enable bit while the pin is already low is allowed. After that the byte can only be changed once the pin has been raised. The new status contents are held while the write cycle runs and are applied at its end, so a cycle that was granted always completes, even if the pin drops while it runs.

Top module: `srwp_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00 (latch, busy, lock and protect-enable bits clear) and no grant or deny pulse is present.
- R2: A write-enable request while idle sets status bit 1. A status or array write made while bit 1 is clear is denied and leaves the status byte unchanged.
- R3: While the protect-enable bit (bit 7) is 0, a status write with the latch set is granted whatever the pin level. Data bit 7 lands in bit 7 and data bits 3:2 land in bits 3:2 when the write cycle ends.
- R4: While the write-protect pin is high, a status write with the latch set is granted even when bit 7 is 1.
- R5: While bit 7 is 1 and the pin is low, a status write is denied, leaves bits 7 and 3:2 unchanged, and clears the latch.
- R6: A status write made with the pin low and bit 7 at 0 may set bit 7. Later status writes with the pin still low are then denied.
- R7: A granted status write completes with its data even if the pin falls during the write cycle. Only requests made after the fall are blocked.
- R8: Data bits 6:4 and 1:0 of a status write are ignored. Status bits 6:4 always read 0, and bits 1:0 are never loaded from the data.
- R9: The lock field in bits 3:2 selects the protected region: 00 none, 01 the top quarter of the address space, 10 the top half, 11 everything. An array write inside the region is denied and clears the latch.
- R10: A granted write clears the latch and sets bit 0 for exactly WR_CYCLES cycles, starting on the edge that registers the grant.
- R11: While bit 0 is 1, status and array writes are denied and change nothing, and write-enable requests are ignored.
- R12: Grant and deny pulses are mutually exclusive. When a status write and an array write arrive in the same cycle, only the status write is served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wp_pin | input | 1 | Write-protect pin level, low means protect |
| wren_req | input | 1 | Decoded write-enable request (one cycle) |
| sr_wr_req | input | 1 | Decoded status write request (one cycle) |
| sr_wr_data | input | 8 | Data byte of the status write |
| arr_wr_req | input | 1 | Decoded array write request (one cycle) |
| arr_wr_addr | input | ADDR_W | Target address of the array write |
| stat_rd | output | 8 | Status byte: bit 7 protect-enable, bits 3:2 lock field, bit 1 latch, bit 0 busy |
| sr_grant | output | 1 | Status write accepted |
| sr_deny | output | 1 | Status write refused |
| arr_grant | output | 1 | Array write accepted |
| arr_deny | output | 1 | Array write refused |

## Verification
The case that needs care is a fall of the write-protect pin while a granted status write is still running, so that the lock engages while the pending data is being applied. The bench grants a status write that sets the protect-enable bit with the pin high, then drops the pin one cycle later. It checks that the new byte still appears when the busy flag clears, and that the next status write with the pin low is refused. A second case issues requests while the busy flag is high. Those requests must be refused and must leave no trace in the byte once the cycle ends.

// File: rtl/srwp_pkg.sv
package srwp_pkg;

    localparam int BIT_BUSY  = 0;
    localparam int BIT_LATCH = 1;
    localparam int BIT_LK_LO = 2;
    localparam int BIT_LK_HI = 3;
    localparam int BIT_PEN   = 7;

    // Data bits a status write may load; the rest are dropped
    localparam logic [7:0] SR_WR_MASK = 8'h8C;

    typedef struct packed {
        logic       pen;
        logic [1:0] lock;
        logic       latch;
        logic       pend_sr;
        logic [7:0] pend_data;
        logic       sr_grant;
        logic       sr_deny;
        logic       arr_grant;
        logic       arr_deny;
    } srwp_state_t;

endpackage

// File: rtl/srwp_region_check.sv
module srwp_region_check #(
    parameter int ADDR_W = 16
) (
    input  logic [1:0]        lock,
    input  logic [ADDR_W-1:0] addr,
    output logic              locked
);
    localparam logic [ADDR_W-1:0] QUARTER = ADDR_W'(1) << (ADDR_W - 2);
    localparam logic [ADDR_W-1:0] BASE_Q3 = ADDR_W'(3) << (ADDR_W - 2);
    localparam logic [ADDR_W-1:0] BASE_H  = QUARTER << 1;

    always_comb begin
        unique case (lock)
            2'b00:   locked = 1'b0;
            2'b01:   locked = (addr >= BASE_Q3);
            2'b10:   locked = (addr >= BASE_H);
            default: locked = 1'b1;
        endcase
    end
endmodule

// File: rtl/srwp_policy.sv
module srwp_policy #(
    parameter int ADDR_W = 16
) (
    input  logic              busy,
    input  logic              latch,
    input  logic              pen,
    input  logic [1:0]        lock,
    input  logic              wp_pin,
    input  logic              sr_req,
    input  logic              arr_req,
    input  logic [ADDR_W-1:0] arr_addr,
    output logic              sr_ok,
    output logic              sr_lockout,
    output logic              arr_ok,
    output logic              arr_lockout
);
    logic region_hit;
    logic sr_frozen;
    logic arr_live;

    srwp_region_check #(.ADDR_W(ADDR_W)) u_region (
        .lock   (lock),
        .addr   (arr_addr),
        .locked (region_hit)
    );

    always_comb begin
        sr_frozen   = pen && !wp_pin;
        arr_live    = arr_req && !sr_req;
        sr_ok       = sr_req && !busy && latch && !sr_frozen;
        sr_lockout  = sr_req && !busy && latch && sr_frozen;
        arr_ok      = arr_live && !busy && latch && !region_hit;
        arr_lockout = arr_live && !busy && latch && region_hit;
    end
endmodule

// File: rtl/srwp_cycle_timer.sv
module srwp_cycle_timer #(
    parameter int CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;

    logic          busy_d, busy_q;
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        busy_d = busy_q;
        cnt_d  = cnt_q;
        done   = busy_q && (cnt_q == '0);
        if (start && !busy_q) begin
            busy_d = 1'b1;
            cnt_d  = CW'(CYC - 1);
        end else if (done) begin
            busy_d = 1'b0;
        end else if (busy_q) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            busy_q <= busy_d;
            cnt_q  <= cnt_d;
        end
    end

    assign busy = busy_q;
endmodule

// File: rtl/srwp_ctrl.sv
module srwp_ctrl
    import srwp_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int WR_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_pin,
    input  logic              wren_req,
    input  logic              sr_wr_req,
    input  logic [7:0]        sr_wr_data,
    input  logic              arr_wr_req,
    input  logic [ADDR_W-1:0] arr_wr_addr,
    output logic [7:0]        stat_rd,
    output logic              sr_grant,
    output logic              sr_deny,
    output logic              arr_grant,
    output logic              arr_deny
);
    srwp_state_t st_d, st_q;

    logic busy, done;
    logic sr_ok, sr_lockout, arr_ok, arr_lockout;

    srwp_policy #(.ADDR_W(ADDR_W)) u_policy (
        .busy        (busy),
        .latch       (st_q.latch),
        .pen         (st_q.pen),
        .lock        (st_q.lock),
        .wp_pin      (wp_pin),
        .sr_req      (sr_wr_req),
        .arr_req     (arr_wr_req),
        .arr_addr    (arr_wr_addr),
        .sr_ok       (sr_ok),
        .sr_lockout  (sr_lockout),
        .arr_ok      (arr_ok),
        .arr_lockout (arr_lockout)
    );

    srwp_cycle_timer #(.CYC(WR_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (sr_ok || arr_ok),
        .busy  (busy),
        .done  (done)
    );

    always_comb begin
        st_d           = st_q;
        st_d.sr_grant  = 1'b0;
        st_d.sr_deny   = 1'b0;
        st_d.arr_grant = 1'b0;
        st_d.arr_deny  = 1'b0;

        // Pending status data is applied unconditionally at cycle end
        if (done && st_q.pend_sr) begin
            st_d.pen     = st_q.pend_data[BIT_PEN];
            st_d.lock    = st_q.pend_data[BIT_LK_HI:BIT_LK_LO];
            st_d.pend_sr = 1'b0;
        end

        if (sr_wr_req) begin
            st_d.sr_grant = sr_ok;
            st_d.sr_deny  = !sr_ok;
            if (sr_ok) begin
                st_d.latch     = 1'b0;
                st_d.pend_sr   = 1'b1;
                st_d.pend_data = sr_wr_data & SR_WR_MASK;
            end else if (sr_lockout) begin
                st_d.latch = 1'b0;
            end
        end else if (arr_wr_req) begin
            st_d.arr_grant = arr_ok;
            st_d.arr_deny  = !arr_ok;
            if (arr_ok || arr_lockout) begin
                st_d.latch = 1'b0;
            end
        end else if (wren_req && !busy) begin
            st_d.latch = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        stat_rd            = '0;
        stat_rd[BIT_PEN]   = st_q.pen;
        stat_rd[BIT_LK_HI:BIT_LK_LO] = st_q.lock;
        stat_rd[BIT_LATCH] = st_q.latch;
        stat_rd[BIT_BUSY]  = busy;
    end

    assign sr_grant  = st_q.sr_grant;
    assign sr_deny   = st_q.sr_deny;
    assign arr_grant = st_q.arr_grant;
    assign arr_deny  = st_q.arr_deny;
endmodule

// File: rtl/srwp_ctrl_checker.sv
module srwp_ctrl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wp_pin,
    input logic       wren_req,
    input logic       sr_wr_req,
    input logic       arr_wr_req,
    input logic [7:0] stat_rd,
    input logic       sr_grant,
    input logic       sr_deny,
    input logic       arr_grant,
    input logic       arr_deny
);
    a_r1_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sr_grant, sr_deny, arr_grant, arr_deny}));

    a_r2_no_latch_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr_req || arr_wr_req) && !stat_rd[1] |=> !sr_grant && !arr_grant);

    a_r3_fields_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rd[0] |=> $stable({stat_rd[7], stat_rd[3:2]}));

    a_r5_frozen_denied: assert property (@(posedge clk) disable iff (!rst_n)
        sr_wr_req && stat_rd[7] && !wp_pin && !stat_rd[0] |=> sr_deny && !stat_rd[1]);

    a_r8_gap_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd[6:4] == 3'b000);

    a_r9_full_lock_denied: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_req && !sr_wr_req && stat_rd[3:2] == 2'b11 && !stat_rd[0] |=> arr_deny);

    a_r10_grant_starts_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_grant || arr_grant) |-> stat_rd[0] && !stat_rd[1]);

    a_r11_busy_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr_req || arr_wr_req) && stat_rd[0] |=> !sr_grant && !arr_grant);

    a_r11_busy_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
        wren_req && stat_rd[0] && !stat_rd[1] |=> !stat_rd[1]);
endmodule

bind srwp_ctrl srwp_ctrl_checker u_srwp_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wp_pin     (wp_pin),
    .wren_req   (wren_req),
    .sr_wr_req  (sr_wr_req),
    .arr_wr_req (arr_wr_req),
    .stat_rd    (stat_rd),
    .sr_grant   (sr_grant),
    .sr_deny    (sr_deny),
    .arr_grant  (arr_grant),
    .arr_deny   (arr_deny)
);

// File: tb/srwp_ctrl_bench.sv
module srwp_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 16;
    localparam int WR_CYCLES  = 8;
    localparam int NVEC       = 21;

    typedef struct packed {
        logic [1:0]  op;        // 0 write-enable, 1 status write, 2 array write
        logic        wp;
        logic [7:0]  data;
        logic [15:0] addr;
        logic        exp_grant;
        logic [7:0]  exp_sr;
        logic [4:0]  tag;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{2'd2, 1'b1, 8'h00, 16'h0000, 1'b0, 8'h00, 5'd2},  // R2 no latch
        '{2'd0, 1'b1, 8'h00, 16'h0000, 1'b0, 8'h02, 5'd2},  // R2 latch set
        '{2'd1, 1'b0, 8'h04, 16'h0000, 1'b1, 8'h04, 5'd3},  // R3 pin low ignored
        '{2'd0, 1'b0, 8'h00, 16'h0000, 1'b0, 8'h06, 5'd2},
        '{2'd2, 1'b0, 8'h00, 16'hC000, 1'b0, 8'h04, 5'd9},  // R9 top quarter
        '{2'd0, 1'b0, 8'h00, 16'h0000, 1'b0, 8'h06, 5'd2},
        '{2'd2, 1'b0, 8'h00, 16'hBFFF, 1'b1, 8'h04, 5'd10}, // R10 below quarter
        '{2'd0, 1'b0, 8'h00, 16'h0000, 1'b0, 8'h06, 5'd2},
        '{2'd1, 1'b0, 8'h8B, 16'h0000, 1'b1, 8'h88, 5'd6},  // R6 set pen, pin low
        '{2'd0, 1'b0, 8'h00, 16'h0000, 1'b0, 8'h8A, 5'd2},
        '{2'd1, 1'b0, 8'h00, 16'h0000, 1'b0, 8'h88, 5'd5},  // R5 frozen
        '{2'd0, 1'b0, 8'h00, 16'h0000, 1'b0, 8'h8A, 5'd2},
        '{2'd2, 1'b0, 8'h00, 16'h8000, 1'b0, 8'h88, 5'd9},  // R9 top half
        '{2'd0, 1'b0, 8'h00, 16'h0000, 1'b0, 8'h8A, 5'd2},
        '{2'd2, 1'b0, 8'h00, 16'h7FFF, 1'b1, 8'h88, 5'd9},  // R9 below half
        '{2'd0, 1'b1, 8'h00, 16'h0000, 1'b0, 8'h8A, 5'd2},
        '{2'd1, 1'b1, 8'h0C, 16'h0000, 1'b1, 8'h0C, 5'd4},  // R4 pin high
        '{2'd0, 1'b0, 8'h00, 16'h0000, 1'b0, 8'h0E, 5'd2},
        '{2'd2, 1'b0, 8'h00, 16'h0000, 1'b0, 8'h0C, 5'd9},  // R9 whole array
        '{2'd0, 1'b0, 8'h00, 16'h0000, 1'b0, 8'h0E, 5'd2},
        '{2'd1, 1'b0, 8'h00, 16'h0000, 1'b1, 8'h00, 5'd3}   // R3 pin low ignored
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wp_pin = 1'b1;
    logic              wren_req = 1'b0;
    logic              sr_wr_req = 1'b0;
    logic [7:0]        sr_wr_data = '0;
    logic              arr_wr_req = 1'b0;
    logic [ADDR_W-1:0] arr_wr_addr = '0;
    logic [7:0]        stat_rd;
    logic              sr_grant, sr_deny, arr_grant, arr_deny;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    srwp_ctrl #(.ADDR_W(ADDR_W), .WR_CYCLES(WR_CYCLES)) u_srwp_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wp_pin      (wp_pin),
        .wren_req    (wren_req),
        .sr_wr_req   (sr_wr_req),
        .sr_wr_data  (sr_wr_data),
        .arr_wr_req  (arr_wr_req),
        .arr_wr_addr (arr_wr_addr),
        .stat_rd     (stat_rd),
        .sr_grant    (sr_grant),
        .sr_deny     (sr_deny),
        .arr_grant   (arr_grant),
        .arr_deny    (arr_deny)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %02h expected %02h", tag, got, exp);
        end
    endtask

    // Request held for one edge; grant and deny are visible on return
    task automatic issue(input logic [1:0] op, input logic wp, input logic [7:0] d,
                         input logic [15:0] a);
        @(negedge clk);
        wp_pin      = wp;
        sr_wr_data  = d;
        arr_wr_addr = a;
        wren_req    = (op == 2'd0);
        sr_wr_req   = (op == 2'd1);
        arr_wr_req  = (op == 2'd2);
        @(negedge clk);
        wren_req   = 1'b0;
        sr_wr_req  = 1'b0;
        arr_wr_req = 1'b0;
    endtask

    task automatic wait_idle();
        for (int g = 0; g < 100 && stat_rd[0]; g++) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 status after reset", stat_rd, 8'h00);
        chk("R1 pulses after reset", {4'h0, sr_grant, sr_deny, arr_grant, arr_deny}, 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            string tg;
            tg = $sformatf("R%0d vector %0d", VECS[i].tag, i);
            issue(VECS[i].op, VECS[i].wp, VECS[i].data, VECS[i].addr);
            if (VECS[i].op == 2'd1)
                chk({tg, " status grant/deny"}, {6'h0, sr_grant, sr_deny},
                    {6'h0, VECS[i].exp_grant, !VECS[i].exp_grant});
            else if (VECS[i].op == 2'd2)
                chk({tg, " array grant/deny"}, {6'h0, arr_grant, arr_deny},
                    {6'h0, VECS[i].exp_grant, !VECS[i].exp_grant});
            wait_idle();
            chk({tg, " status byte"}, stat_rd, VECS[i].exp_sr);
        end

        // R10: busy width and latch clear
        begin
            int cnt = 0;
            issue(2'd0, 1'b1, 8'h00, 16'h0000);
            issue(2'd2, 1'b1, 8'h00, 16'h1234);
            chk("R10 array grant", {7'h0, arr_grant}, 8'h01);
            chk("R10 latch cleared, busy set", {6'h0, stat_rd[1:0]}, 8'h01);
            while (stat_rd[0] && cnt < 100) begin
                cnt++;
                @(negedge clk);
            end
            chk("R10 busy cycles", 8'(cnt), 8'(WR_CYCLES));
        end

        // R11: requests while busy
        issue(2'd0, 1'b1, 8'h00, 16'h0000);
        issue(2'd2, 1'b1, 8'h00, 16'h0000);
        issue(2'd1, 1'b1, 8'h0C, 16'h0000);
        chk("R11 status write while busy denied", {6'h0, sr_grant, sr_deny}, 8'h01);
        issue(2'd0, 1'b1, 8'h00, 16'h0000);
        wait_idle();
        chk("R11 busy requests left no trace", stat_rd, 8'h00);

        // R12: simultaneous status and array write
        issue(2'd0, 1'b1, 8'h00, 16'h0000);
        @(negedge clk);
        sr_wr_data = 8'h04;
        arr_wr_addr = 16'h0000;
        sr_wr_req = 1'b1;
        arr_wr_req = 1'b1;
        @(negedge clk);
        sr_wr_req = 1'b0;
        arr_wr_req = 1'b0;
        chk("R12 status served, array silent",
            {4'h0, sr_grant, sr_deny, arr_grant, arr_deny}, 8'h08);
        wait_idle();
        chk("R12 status byte", stat_rd, 8'h04);

        // R7: pin falls during a granted status write
        issue(2'd0, 1'b1, 8'h00, 16'h0000);
        issue(2'd1, 1'b1, 8'h8C, 16'h0000);
        chk("R7 status grant", {6'h0, sr_grant, sr_deny}, 8'h02);
        @(negedge clk);
        wp_pin = 1'b0;
        wait_idle();
        chk("R7 in-flight write completed", stat_rd, 8'h8C);
        issue(2'd0, 1'b0, 8'h00, 16'h0000);
        issue(2'd1, 1'b0, 8'h00, 16'h0000);
        chk("R7 later write denied", {6'h0, sr_grant, sr_deny}, 8'h01);
        wait_idle();
        chk("R7 byte unchanged", stat_rd, 8'h8C);

        // R8: ignored data bits
        issue(2'd0, 1'b1, 8'h00, 16'h0000);
        issue(2'd1, 1'b1, 8'h73, 16'h0000);
        chk("R8 status grant", {6'h0, sr_grant, sr_deny}, 8'h02);
        wait_idle();
        chk("R8 ignored bits", stat_rd, 8'h00);

        // R1: reset clears a set latch
        issue(2'd0, 1'b1, 8'h00, 16'h0000);
        chk("R1 latch set before reset", stat_rd, 8'h02);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 status after second reset", stat_rd, 8'h00);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule